// File: doc/BRIEF.md
# Landing-Pad Forward-Edge Guard

This block enforces forward-edge control-flow integrity beside a core that retires at most one instruction per cycle. It keeps a single "landing pad expected" bit. A retiring indirect jump sets that bit when the jump's mode has the feature turned on. The next instruction to retire must then be a landing-pad instruction that passes its label and alignment checks. If it is not, the block raises a software-check fault.

Decode and the CSR file sit outside the block. The core supplies the following:
- the retired instruction word, an indirect-jump flag and the jump's base register index;
- the low PC bits and bits 31:12 of register x7;
- the current privilege and virtualization mode;
- the per-mode enable bits;
- strobes for traps, returns and debug entry and exit.

The block keeps the previous-expected copies for supervisor, machine and debug. Traps and debug entry save the expected bit into those copies. Returns and debug exit restore it.

Top module: `lp_cfi_guard`

## Requirements
- R1: After reset the expected bit, the three saved copies and the fault strobe are all 0.
- R2: A retiring indirect jump in an enabled mode sets the expected bit to 0 when its base register index is 1, 5 or 7. For any other index it sets the bit to 1.
- R3: An indirect jump that retires in a mode whose enable is 0 leaves the expected bit unchanged.
- R4: While the expected bit is 1, a retiring instruction whose bits [11:0] differ from 12'h017 raises `fault` for exactly one cycle, starting the cycle after it retires. During that cycle `fault_cause` is 18 and `fault_tval` is 2. The offending instruction does not change the expected bit.
- R5: While the expected bit is 1 and the mode is enabled, a landing pad (bits [11:0] = 12'h017) can pass its check. It passes when its PC bits [1:0] are 0 and its label (bits [31:12]) is either zero or equal to x7 bits [31:12]. A passing landing pad clears the expected bit and raises no fault.
- R6: A landing pad that is checked while the expected bit is 1 raises the R4 fault if its label is nonzero and differs from x7 bits [31:12]. It also raises the fault if its PC bits [1:0] are nonzero. In either case the expected bit stays unchanged.
- R7: The enable for a mode is chosen as follows, with privilege encoded U=0, S=1, M=3:
  - user mode uses `cfg_s_lpe` when `has_smode` is 1, otherwise `cfg_m_lpe`;
  - supervisor mode uses `cfg_h_lpe` when virtualized, otherwise `cfg_m_lpe`;
  - machine mode uses `cfg_sec_lpe`;
  - privilege 2 is never enabled.
- R8: `trap_to_s` copies the expected bit into `spelp` and clears it. `trap_to_m` does the same into `mpelp`.
- R9: `sret` and `mret` act only when the mode given by `rtn_priv`/`rtn_virt` is enabled. They then load the expected bit from `spelp` or `mpelp` respectively and clear that copy. When the target mode is disabled, both the bit and the copy are unchanged.
- R10: `dbg_enter` copies the expected bit into `dpelp` and clears it. `dbg_exit` restores the bit from `dpelp` when the `rtn_priv`/`rtn_virt` mode is enabled, and leaves `dpelp` unchanged.
- R11: When strobes coincide, the one highest in this list is the only one that acts:
  1. `dbg_enter`
  2. `trap_to_m`
  3. `trap_to_s`
  4. `dbg_exit`
  5. `mret`
  6. `sret`
  7. retirement

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_insn | input | 32 | Retired instruction word |
| ret_pc_lo | input | 2 | PC bits [1:0] of the retired instruction |
| ret_is_ijump | input | 1 | Retired instruction is an indirect jump |
| ret_base_reg | input | 5 | Base register index of the indirect jump |
| x7_label | input | 20 | Bits [31:12] of register x7 |
| priv | input | 2 | Current privilege (U=0, S=1, M=3) |
| virt | input | 1 | Current virtualization mode |
| has_smode | input | 1 | Supervisor mode exists |
| cfg_m_lpe | input | 1 | Machine environment enable |
| cfg_s_lpe | input | 1 | Supervisor environment enable |
| cfg_h_lpe | input | 1 | Hypervisor environment enable |
| cfg_sec_lpe | input | 1 | Machine security enable |
| trap_to_s | input | 1 | Trap taken into supervisor mode |
| trap_to_m | input | 1 | Trap taken into machine mode |
| sret | input | 1 | Supervisor return |
| mret | input | 1 | Machine return |
| dbg_enter | input | 1 | Debug mode entry |
| dbg_exit | input | 1 | Debug mode return |
| rtn_priv | input | 2 | Privilege returned to |
| rtn_virt | input | 1 | Virtualization mode returned to |
| fault | output | 1 | Software-check fault strobe |
| fault_cause | output | 6 | Exception cause, 18 while faulting |
| fault_tval | output | 64 | Fault value, 2 while faulting |
| elp | output | 1 | Landing pad expected |
| spelp | output | 1 | Supervisor previous-expected copy |
| mpelp | output | 1 | Machine previous-expected copy |
| dpelp | output | 1 | Debug previous-expected copy |

## Verification
The hardest condition to reach is an armed state that survives a trap and comes back through a return. The trap must be taken while the bit is 1, and the later return must target a mode whose enable is on. The bench arms the bit with a jump, faults it with an ordinary instruction and takes a machine trap. It then issues `mret` with machine mode enabled and checks that the bit is 1 again, so a following landing pad is checked. The same route is taken with the target mode disabled, and with the strobes coinciding with a retirement.

// File: rtl/lp_cfi_pkg.sv
package lp_cfi_pkg;
    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam int          PAD_OP_W      = 12;
    localparam logic [11:0] PAD_OPCODE    = 12'h017;
    localparam int          CAUSE_W       = 6;
    localparam logic [5:0]  SWCHECK_CAUSE = 6'd18;
    localparam int          PAD_FAULT_VAL = 2;

    typedef struct packed {
        logic elp;
        logic spelp;
        logic mpelp;
        logic dpelp;
        logic fault;
    } lp_state_t;

    function automatic logic is_link_reg(input logic [4:0] idx);
        return (idx == 5'd1) || (idx == 5'd5) || (idx == 5'd7);
    endfunction
endpackage

// File: rtl/lp_mode_enable.sv
module lp_mode_enable
    import lp_cfi_pkg::*;
(
    input  logic [1:0] priv,
    input  logic       virt,
    input  logic       has_smode,
    input  logic       cfg_m_lpe,
    input  logic       cfg_s_lpe,
    input  logic       cfg_h_lpe,
    input  logic       cfg_sec_lpe,
    output logic       en
);
    always_comb begin
        case (priv)
            PRIV_U:  en = has_smode ? cfg_s_lpe : cfg_m_lpe;
            PRIV_S:  en = virt ? cfg_h_lpe : cfg_m_lpe;
            PRIV_M:  en = cfg_sec_lpe;
            default: en = 1'b0;
        endcase
    end
endmodule

// File: rtl/lp_pad_check.sv
module lp_pad_check
    import lp_cfi_pkg::*;
#(
    parameter int INSN_W  = 32,
    parameter int LABEL_W = 20
) (
    input  logic [INSN_W-1:0]  insn,
    input  logic [1:0]         pc_lo,
    input  logic [LABEL_W-1:0] x7_label,
    output logic               is_pad,
    output logic               pad_ok
);
    localparam int OP_W = INSN_W - LABEL_W;

    logic [LABEL_W-1:0] label;

    always_comb begin
        label  = insn[INSN_W-1:OP_W];
        is_pad = (insn[OP_W-1:0] == PAD_OPCODE[OP_W-1:0]);
        pad_ok = (pc_lo == 2'b00) && ((label == '0) || (label == x7_label));
    end

    initial begin
        // R5
        opw_chk: assert (OP_W == PAD_OP_W);
    end
endmodule

// File: rtl/lp_cfi_guard.sv
module lp_cfi_guard
    import lp_cfi_pkg::*;
#(
    parameter int INSN_W  = 32,
    parameter int LABEL_W = 20,
    parameter int REG_W   = 5,
    parameter int TVAL_W  = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ret_valid,
    input  logic [INSN_W-1:0]  ret_insn,
    input  logic [1:0]         ret_pc_lo,
    input  logic               ret_is_ijump,
    input  logic [REG_W-1:0]   ret_base_reg,
    input  logic [LABEL_W-1:0] x7_label,
    input  logic [1:0]         priv,
    input  logic               virt,
    input  logic               has_smode,
    input  logic               cfg_m_lpe,
    input  logic               cfg_s_lpe,
    input  logic               cfg_h_lpe,
    input  logic               cfg_sec_lpe,
    input  logic               trap_to_s,
    input  logic               trap_to_m,
    input  logic               sret,
    input  logic               mret,
    input  logic               dbg_enter,
    input  logic               dbg_exit,
    input  logic [1:0]         rtn_priv,
    input  logic               rtn_virt,
    output logic               fault,
    output logic [CAUSE_W-1:0] fault_cause,
    output logic [TVAL_W-1:0]  fault_tval,
    output logic               elp,
    output logic               spelp,
    output logic               mpelp,
    output logic               dpelp
);
    lp_state_t st_d, st_q;
    logic      cur_en, tgt_en;
    logic      is_pad, pad_ok;

    lp_mode_enable u_cur_en (
        .priv(priv), .virt(virt), .has_smode(has_smode),
        .cfg_m_lpe(cfg_m_lpe), .cfg_s_lpe(cfg_s_lpe),
        .cfg_h_lpe(cfg_h_lpe), .cfg_sec_lpe(cfg_sec_lpe), .en(cur_en)
    );

    lp_mode_enable u_tgt_en (
        .priv(rtn_priv), .virt(rtn_virt), .has_smode(has_smode),
        .cfg_m_lpe(cfg_m_lpe), .cfg_s_lpe(cfg_s_lpe),
        .cfg_h_lpe(cfg_h_lpe), .cfg_sec_lpe(cfg_sec_lpe), .en(tgt_en)
    );

    lp_pad_check #(.INSN_W(INSN_W), .LABEL_W(LABEL_W)) u_pad (
        .insn(ret_insn), .pc_lo(ret_pc_lo), .x7_label(x7_label),
        .is_pad(is_pad), .pad_ok(pad_ok)
    );

    always_comb begin
        st_d       = st_q;
        st_d.fault = 1'b0;
        if (dbg_enter) begin
            st_d.dpelp = st_q.elp;
            st_d.elp   = 1'b0;
        end else if (trap_to_m) begin
            st_d.mpelp = st_q.elp;
            st_d.elp   = 1'b0;
        end else if (trap_to_s) begin
            st_d.spelp = st_q.elp;
            st_d.elp   = 1'b0;
        end else if (dbg_exit) begin
            if (tgt_en) st_d.elp = st_q.dpelp;
        end else if (mret) begin
            if (tgt_en) begin
                st_d.elp   = st_q.mpelp;
                st_d.mpelp = 1'b0;
            end
        end else if (sret) begin
            if (tgt_en) begin
                st_d.elp   = st_q.spelp;
                st_d.spelp = 1'b0;
            end
        end else if (ret_valid) begin
            if (st_q.elp && !is_pad) begin
                st_d.fault = 1'b1;
            end else if (st_q.elp && is_pad && cur_en) begin
                if (pad_ok) st_d.elp   = 1'b0;
                else        st_d.fault = 1'b1;
            end else if (ret_is_ijump && cur_en) begin
                st_d.elp = !is_link_reg(ret_base_reg);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fault       = st_q.fault;
    assign fault_cause = st_q.fault ? SWCHECK_CAUSE : '0;
    assign fault_tval  = st_q.fault ? TVAL_W'(PAD_FAULT_VAL) : '0;
    assign elp         = st_q.elp;
    assign spelp       = st_q.spelp;
    assign mpelp       = st_q.mpelp;
    assign dpelp       = st_q.dpelp;

    logic any_event;
    assign any_event = dbg_enter | trap_to_m | trap_to_s | dbg_exit | mret | sret;

    // R4
    fault_needs_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $past(st_q.elp) && $stable(st_q.elp));

    // R2
    arm_from_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_is_ijump && cur_en && !st_q.elp && !any_event)
        |=> (st_q.elp == !$past(is_link_reg(ret_base_reg))));

    // R8
    trap_m_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_to_m && !dbg_enter) |=> (!st_q.elp && st_q.mpelp == $past(st_q.elp)));

    // R10
    dbg_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_enter |=> (!st_q.elp && st_q.dpelp == $past(st_q.elp)));

    // R9
    mret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mret && tgt_en && !dbg_enter && !trap_to_m && !trap_to_s && !dbg_exit)
        |=> (!st_q.mpelp && st_q.elp == $past(st_q.mpelp)));
endmodule

// File: tb/lp_cfi_guard_test.sv
module lp_cfi_guard_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ret_valid = 0, ret_is_ijump = 0, virt = 0, has_smode = 0, rtn_virt = 0;
    logic [31:0] ret_insn = 32'h13;
    logic [1:0]  ret_pc_lo = 0, priv = 2'd3, rtn_priv = 2'd3;
    logic [4:0]  ret_base_reg = 0;
    logic [19:0] x7_label = 0;
    logic cfg_m_lpe = 0, cfg_s_lpe = 0, cfg_h_lpe = 0, cfg_sec_lpe = 0;
    logic trap_to_s = 0, trap_to_m = 0, sret = 0, mret = 0, dbg_enter = 0, dbg_exit = 0;
    logic fault, elp, spelp, mpelp, dpelp;
    logic [5:0]  fault_cause;
    logic [63:0] fault_tval;

    int total = 0;
    int bad = 0;

    localparam logic [31:0] NOP = 32'h0000_0013;

    always #2 clk = ~clk;

    lp_cfi_guard uut (
        .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_insn(ret_insn),
        .ret_pc_lo(ret_pc_lo), .ret_is_ijump(ret_is_ijump), .ret_base_reg(ret_base_reg),
        .x7_label(x7_label), .priv(priv), .virt(virt), .has_smode(has_smode),
        .cfg_m_lpe(cfg_m_lpe), .cfg_s_lpe(cfg_s_lpe), .cfg_h_lpe(cfg_h_lpe),
        .cfg_sec_lpe(cfg_sec_lpe), .trap_to_s(trap_to_s), .trap_to_m(trap_to_m),
        .sret(sret), .mret(mret), .dbg_enter(dbg_enter), .dbg_exit(dbg_exit),
        .rtn_priv(rtn_priv), .rtn_virt(rtn_virt), .fault(fault),
        .fault_cause(fault_cause), .fault_tval(fault_tval), .elp(elp),
        .spelp(spelp), .mpelp(mpelp), .dpelp(dpelp)
    );

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] pad(input logic [19:0] lbl);
        return {lbl, 12'h017};
    endfunction

    task automatic retire(input logic [31:0] insn, input logic [1:0] pclo,
                          input logic ij, input int base);
        ret_valid = 1; ret_insn = insn; ret_pc_lo = pclo;
        ret_is_ijump = ij; ret_base_reg = base[4:0];
        tick();
        ret_valid = 0; ret_is_ijump = 0; ret_insn = NOP; ret_pc_lo = 0;
    endtask

    task automatic event_pulse(input int kind);
        case (kind)
            0: dbg_enter = 1;
            1: trap_to_m = 1;
            2: trap_to_s = 1;
            3: dbg_exit  = 1;
            4: mret      = 1;
            default: sret = 1;
        endcase
        tick();
        dbg_enter = 0; trap_to_m = 0; trap_to_s = 0;
        dbg_exit = 0; mret = 0; sret = 0;
    endtask

    function automatic logic exp_en(input int p, input logic v, input logic hs,
                                    input logic m, input logic s, input logic h,
                                    input logic sc);
        case (p)
            0: return hs ? s : m;
            1: return v ? h : m;
            3: return sc;
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        #(4 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R1 reset state
        check("R1 elp", elp, 0);
        check("R1 spelp", spelp, 0);
        check("R1 mpelp", mpelp, 0);
        check("R1 dpelp", dpelp, 0);
        check("R1 fault", fault, 0);
        rst_n = 1;
        tick();

        // R7 enable selection sweep, observed via arming
        for (int p = 0; p < 4; p++) begin
            for (int cfg = 0; cfg < 64; cfg++) begin
                logic e;
                priv = p[1:0]; virt = cfg[0]; has_smode = cfg[1];
                cfg_m_lpe = cfg[2]; cfg_s_lpe = cfg[3]; cfg_h_lpe = cfg[4]; cfg_sec_lpe = cfg[5];
                e = exp_en(p, cfg[0], cfg[1], cfg[2], cfg[3], cfg[4], cfg[5]);
                retire(NOP, 0, 1, 9);
                check("R7 enable select", elp, e);
                if (e) begin
                    retire(pad(20'h0), 0, 0, 0);
                    check("R5 zero label clears", elp, 0);
                end
            end
        end

        // Machine mode enabled from here
        priv = 2'd3; virt = 0; has_smode = 1;
        cfg_m_lpe = 0; cfg_s_lpe = 0; cfg_h_lpe = 0; cfg_sec_lpe = 1;

        // R2 base register sweep
        for (int r = 0; r < 32; r++) begin
            logic e;
            e = !(r == 1 || r == 5 || r == 7);
            retire(NOP, 0, 1, r);
            check("R2 base reg", elp, e);
            if (e) begin
                retire(pad(20'h0), 0, 0, 0);
                check("R5 clear", elp, 0);
            end
        end
        // R2: link register clears an armed bit? armed bit faults first; check link-only path
        retire(NOP, 0, 1, 5);
        check("R2 x5 no arm", elp, 0);

        // R3 disabled mode: jump leaves bit
        cfg_sec_lpe = 0;
        retire(NOP, 0, 1, 9);
        check("R3 disabled jump", elp, 0);
        cfg_sec_lpe = 1;

        // R5 label match sweep
        for (int k = 0; k < 8; k++) begin
            logic [19:0] lbl;
            lbl = 20'h1 << (k * 2);
            x7_label = lbl;
            retire(NOP, 0, 1, 10);
            retire(pad(lbl), 0, 0, 0);
            check("R5 match no fault", fault, 0);
            check("R5 match clears", elp, 0);
        end

        // R6 label mismatch
        x7_label = 20'h00abc;
        retire(NOP, 0, 1, 11);
        retire(pad(20'h00abd), 0, 0, 0);
        check("R6 mismatch fault", fault, 1);
        check("R6 mismatch cause", fault_cause, 18);
        check("R6 mismatch tval", fault_tval, 2);
        check("R6 mismatch elp held", elp, 1);
        tick();
        check("R4 strobe one cycle", fault, 0);
        retire(pad(20'h00abc), 0, 0, 0);
        check("R5 matching clears", elp, 0);

        // R6 misaligned, for each nonzero pc low value
        for (int m = 1; m < 4; m++) begin
            retire(NOP, 0, 1, 12);
            retire(pad(20'h0), m[1:0], 0, 0);
            check("R6 misaligned fault", fault, 1);
            check("R6 misaligned elp held", elp, 1);
            retire(pad(20'h0), 0, 0, 0);
            check("R6 aligned retry clears", elp, 0);
            check("R6 aligned retry no fault", fault, 0);
        end

        // R4 non-pad after jump, then trap/return restoring armed bit
        retire(NOP, 0, 1, 13);
        retire(NOP, 0, 0, 0);
        check("R4 nonpad fault", fault, 1);
        check("R4 cause", fault_cause, 18);
        check("R4 tval", fault_tval, 2);
        check("R4 elp held", elp, 1);
        event_pulse(1);
        check("R4 strobe ends", fault, 0);
        check("R8 trap M saves", mpelp, 1);
        check("R8 trap M clears", elp, 0);
        rtn_priv = 2'd3;
        event_pulse(4);
        check("R9 mret restores", elp, 1);
        check("R9 mret clears copy", mpelp, 0);
        retire(pad(20'h0), 0, 0, 0);
        check("R9 restored bit checked", elp, 0);

        // R8/R9 supervisor path with disabled then enabled target
        retire(NOP, 0, 1, 14);
        event_pulse(2);
        check("R8 trap S saves", spelp, 1);
        check("R8 trap S clears", elp, 0);
        rtn_priv = 2'd0; rtn_virt = 0; cfg_s_lpe = 0;
        event_pulse(5);
        check("R9 sret disabled elp", elp, 0);
        check("R9 sret disabled copy", spelp, 1);
        cfg_s_lpe = 1;
        event_pulse(5);
        check("R9 sret restores", elp, 1);
        check("R9 sret clears copy", spelp, 0);

        // R10 debug entry/exit
        event_pulse(0);
        check("R10 dbg save", dpelp, 1);
        check("R10 dbg clear", elp, 0);
        rtn_priv = 2'd1; rtn_virt = 1; cfg_h_lpe = 0;
        event_pulse(3);
        check("R10 dbg exit disabled", elp, 0);
        cfg_h_lpe = 1;
        event_pulse(3);
        check("R10 dbg exit restores", elp, 1);
        check("R10 dpelp kept", dpelp, 1);

        // R11 priority: trap_to_s with retire of nonpad -> no fault
        ret_valid = 1; ret_insn = NOP; trap_to_s = 1;
        tick();
        ret_valid = 0; trap_to_s = 0;
        check("R11 trap over retire fault", fault, 0);
        check("R11 trap saved", spelp, 1);
        check("R11 trap cleared", elp, 0);
        // R11 dbg_enter over trap_to_m
        retire(NOP, 0, 1, 15);
        dbg_enter = 1; trap_to_m = 1;
        tick();
        dbg_enter = 0; trap_to_m = 0;
        check("R11 dbg wins dpelp", dpelp, 1);
        check("R11 dbg wins mpelp", mpelp, 0);
        // R11 jump with event: jump ignored
        rtn_priv = 2'd3; cfg_sec_lpe = 1;
        ret_valid = 1; ret_is_ijump = 1; ret_base_reg = 9; mret = 1;
        tick();
        ret_valid = 0; ret_is_ijump = 0; mret = 0;
        check("R11 mret over jump", elp, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule